// File: doc/BRIEF.md
# Host Interrupt Signalling Selector

This block merges the local interrupt sources of a bridge into one upstream interrupt toward a PCI Express host. There are eight mailbox sources and one local-bus IRQ source. Each source has a status bit and an enable bit. A source takes part only when both bits are set, and the enabled sources are ORed into a single pending signal.

Two configuration-space controls choose how the pending signal reaches the host. The first is the interrupt-disable flag, which comes from bit 10 of the configuration Command register. The second is the MSI-enable flag, which comes from bit 0 of the MSI capability's message control word. When MSI is enabled, each rising edge of the pending signal produces a one-cycle MSI request pulse. When MSI is off and legacy signalling is allowed, a held virtual INTA level follows the pending signal. Each rising edge of that level requests an Assert_INTA message, and each falling edge requests a Deassert_INTA message.

The message layer downstream turns these pulses into TLPs. This block does not build messages and does not handle MSI address or data.

Top module: `irq_route_top`

## Requirements
- R1: The pending signal is the OR over nine sources of (status AND enable). Mailbox bit i of `mbox_status` pairs with bit i of `mbox_enable` (i = 0..7), and `lbus_irq_status` pairs with `lbus_irq_enable`. A status bit whose enable is clear has no effect on any output.
- R2: While `cfg_intx_disable` (Command register bit 10) is 1, `intx_level` stays 0 and no assert request is made. Setting it while `intx_level` is 1 drops the level and produces one deassert request.
- R3: While `cfg_msi_enable` (message control bit 0) is 1, MSI takes precedence over legacy signalling: `intx_level` stays 0 and no assert request is made, whatever the value of `cfg_intx_disable`.
- R4: In legacy mode (MSI off, interrupt disable clear), `intx_level` equals the pending signal sampled at the previous clock edge.
- R5: `intx_assert_req` is high for exactly the one cycle in which `intx_level` goes from 0 to 1.
- R6: `intx_deassert_req` is high for exactly the one cycle in which `intx_level` goes from 1 to 0.
- R7: In MSI mode, `msi_req` pulses for one cycle one clock after the pending signal rises. A pending level that stays high produces no further pulses. A new rise after pending has dropped produces a new pulse.
- R8: If MSI is enabled while `intx_level` is 1 and the interrupt is still pending, the deassert request appears first. `msi_req` follows in the next cycle.
- R9: Active-low synchronous reset clears the INTA level, and all four outputs are 0 in the cycle after a reset edge.
- R10: At most one of `msi_req`, `intx_assert_req` and `intx_deassert_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mbox_status | input | 8 | Mailbox interrupt status bits |
| mbox_enable | input | 8 | Mailbox interrupt enable bits |
| lbus_irq_status | input | 1 | Local-bus IRQ asserted status |
| lbus_irq_enable | input | 1 | Local-bus IRQ enable |
| cfg_intx_disable | input | 1 | Command register bit 10, legacy interrupt disable |
| cfg_msi_enable | input | 1 | MSI message control bit 0, MSI enable |
| msi_req | output | 1 | One-cycle MSI request |
| intx_assert_req | output | 1 | One-cycle request to send Assert_INTA |
| intx_deassert_req | output | 1 | One-cycle request to send Deassert_INTA |
| intx_level | output | 1 | Held virtual INTA level |

## Verification
A stuck or stale INTA flip-flop shows up at the ports in one of two ways. Either a missing deassert request follows a pending drop, or a spurious assert request appears. Both become visible one cycle after the triggering edge. A wrong MSI edge register shows up as repeated `msi_req` pulses while the pending signal is held, or as a missing pulse. During a mode switch, the fault shows as a deassert request and an MSI request that do not occur in consecutive cycles. All of these effects are checked in the first or second cycle after the stimulus.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int MBOX_N = 8;

  typedef enum logic [1:0] {
    SIG_OFF    = 2'd0,
    SIG_LEGACY = 2'd1,
    SIG_MSI    = 2'd2
  } sig_mode_e;

  // MSI wins over legacy; legacy needs its disable flag clear.
  function automatic sig_mode_e pick_mode(input logic intx_off, input logic msi_on);
    if (msi_on)        return SIG_MSI;
    else if (!intx_off) return SIG_LEGACY;
    else               return SIG_OFF;
  endfunction

  function automatic logic went_up(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  function automatic logic went_down(input logic now_v, input logic was_v);
    return ~now_v & was_v;
  endfunction
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N = 9
) (
  input  logic [N-1:0] st,
  input  logic [N-1:0] en,
  output logic         pending
);
  logic [N-1:0] term;

  for (genvar i = 0; i < N; i++) begin : g_term
    assign term[i] = st[i] & en[i];
  end

  assign pending = |term;
endmodule

// File: rtl/irq_mode_sel.sv
module irq_mode_sel
  import irq_route_pkg::*;
(
  input  logic intx_off,
  input  logic msi_on,
  output logic msi_mode,
  output logic legacy_ok
);
  sig_mode_e mode;

  always_comb begin
    mode      = pick_mode(intx_off, msi_on);
    msi_mode  = (mode == SIG_MSI);
    legacy_ok = (mode == SIG_LEGACY);
  end
endmodule

// File: rtl/irq_edge_track.sv
module irq_edge_track
  import irq_route_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic level,
  output logic rise,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= 1'b0;
      prev  <= 1'b0;
    end else begin
      level <= d;
      prev  <= level;
    end
  end

  assign rise = went_up(level, prev);
  assign fall = went_down(level, prev);

  assert_rise_one_cycle_R5_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  assert_fall_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall);
  assert_level_tracks_d_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> $past(d));
endmodule

// File: rtl/irq_route_top.sv
module irq_route_top
  import irq_route_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MBOX_N-1:0]   mbox_status,
  input  logic [MBOX_N-1:0]   mbox_enable,
  input  logic                lbus_irq_status,
  input  logic                lbus_irq_enable,
  input  logic                cfg_intx_disable,
  input  logic                cfg_msi_enable,
  output logic                msi_req,
  output logic                intx_assert_req,
  output logic                intx_deassert_req,
  output logic                intx_level
);
  localparam int SRC_N = MBOX_N + 1;

  logic pending_w, msi_mode_w, legacy_ok_w;
  logic inta_d_w, msi_d_w;
  logic msi_lvl_w, msi_fall_w;

  irq_gate #(.N(SRC_N)) gate_i (
    .st      ({lbus_irq_status, mbox_status}),
    .en      ({lbus_irq_enable, mbox_enable}),
    .pending (pending_w)
  );

  irq_mode_sel mode_i (
    .intx_off  (cfg_intx_disable),
    .msi_on    (cfg_msi_enable),
    .msi_mode  (msi_mode_w),
    .legacy_ok (legacy_ok_w)
  );

  // Legacy INTA set/clear flop input.
  assign inta_d_w = legacy_ok_w & pending_w;
  // MSI path waits until the INTA level has been released.
  assign msi_d_w  = msi_mode_w & pending_w & ~intx_level;

  irq_edge_track inta_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (inta_d_w),
    .level (intx_level),
    .rise  (intx_assert_req),
    .fall  (intx_deassert_req)
  );

  irq_edge_track msi_i (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (msi_d_w),
    .level (msi_lvl_w),
    .rise  (msi_req),
    .fall  (msi_fall_w)
  );

  assert_quiet_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_enable == '0 && !lbus_irq_enable) |-> !pending_w);
  assert_no_assert_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    intx_assert_req |-> $past(!cfg_intx_disable));
  assert_msi_precedence_R3: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> !intx_level);
  assert_msi_from_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req |-> $past(cfg_msi_enable && pending_w));
  assert_deassert_before_msi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (intx_deassert_req && cfg_msi_enable && pending_w) |=> msi_req);
  assert_one_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msi_req, intx_assert_req, intx_deassert_req}));
  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |=> !intx_level && !msi_req);
endmodule

// File: tb/irq_route_top_tb.sv
module irq_route_top_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] mbox_status, mbox_enable;
  logic       lbus_irq_status, lbus_irq_enable;
  logic       cfg_intx_disable, cfg_msi_enable;
  logic       msi_req, intx_assert_req, intx_deassert_req, intx_level;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_route_top dut_i (
    .clk(clk), .rst_n(rst_n),
    .mbox_status(mbox_status), .mbox_enable(mbox_enable),
    .lbus_irq_status(lbus_irq_status), .lbus_irq_enable(lbus_irq_enable),
    .cfg_intx_disable(cfg_intx_disable), .cfg_msi_enable(cfg_msi_enable),
    .msi_req(msi_req), .intx_assert_req(intx_assert_req),
    .intx_deassert_req(intx_deassert_req), .intx_level(intx_level)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    mbox_status = '0; mbox_enable = '0;
    lbus_irq_status = 0; lbus_irq_enable = 0;
    cfg_intx_disable = 0; cfg_msi_enable = 0;
    tick(); tick(); tick();
  endtask

  // R10 watched on every cycle away from the edge.
  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      if ((msi_req + intx_assert_req + intx_deassert_req) > 1) begin
        bad++; total++;
        $display("FAIL R10 requests: actual=%0b%0b%0b expected=at most one",
                 msi_req, intx_assert_req, intx_deassert_req);
      end
    end
  end

  task automatic t_reset();
    rst_n = 0;
    mbox_status = 8'h01; mbox_enable = 8'h01;
    lbus_irq_status = 0; lbus_irq_enable = 0;
    cfg_intx_disable = 0; cfg_msi_enable = 0;
    tick(); tick();
    chk("R9", "level in reset", intx_level, 0);
    chk("R9", "assert in reset", intx_assert_req, 0);
    chk("R9", "msi in reset", msi_req, 0);
    mbox_status = '0; mbox_enable = '0;
    rst_n = 1;
    tick();
    chk("R9", "level after reset", intx_level, 0);
    chk("R9", "deassert after reset", intx_deassert_req, 0);
  endtask

  task automatic t_gating();
    mbox_status = 8'hFF; mbox_enable = 8'h00;
    tick(); tick();
    chk("R1", "status without enable", intx_level, 0);
    chk("R1", "no assert without enable", intx_assert_req, 0);
    mbox_status = 8'h20; mbox_enable = 8'hDF;
    tick();
    chk("R1", "mismatched bits", intx_level, 0);
    mbox_enable = 8'h20;
    tick();
    chk("R4", "level follows pending", intx_level, 1);
    chk("R5", "assert pulse", intx_assert_req, 1);
    tick();
    chk("R5", "assert single cycle", intx_assert_req, 0);
    chk("R4", "level held", intx_level, 1);
    mbox_status = 8'h00;
    tick();
    chk("R6", "deassert pulse", intx_deassert_req, 1);
    chk("R4", "level drops", intx_level, 0);
    tick();
    chk("R6", "deassert single cycle", intx_deassert_req, 0);
    lbus_irq_status = 1; lbus_irq_enable = 1;
    tick();
    chk("R1", "local-bus source", intx_assert_req, 1);
    quiet();
  endtask

  task automatic t_disable();
    cfg_intx_disable = 1;
    mbox_status = 8'h80; mbox_enable = 8'h80;
    tick(); tick();
    chk("R2", "level suppressed", intx_level, 0);
    chk("R2", "no assert while disabled", intx_assert_req, 0);
    cfg_intx_disable = 0;
    tick();
    chk("R2", "assert after enable", intx_assert_req, 1);
    cfg_intx_disable = 1;
    tick();
    chk("R2", "deassert on disable", intx_deassert_req, 1);
    chk("R2", "level dropped", intx_level, 0);
    quiet();
  endtask

  task automatic t_msi();
    cfg_msi_enable = 1; cfg_intx_disable = 0;
    mbox_status = 8'h04; mbox_enable = 8'h04;
    tick();
    chk("R7", "msi pulse", msi_req, 1);
    chk("R3", "no legacy level", intx_level, 0);
    chk("R3", "no assert in msi", intx_assert_req, 0);
    tick(); tick();
    chk("R7", "held pending no repeat", msi_req, 0);
    mbox_status = 8'h00;
    tick();
    mbox_status = 8'h04;
    tick();
    chk("R7", "second rise pulses", msi_req, 1);
    quiet();
  endtask

  task automatic t_switch();
    mbox_status = 8'h02; mbox_enable = 8'h02;
    tick(); tick();
    chk("R8", "legacy level before switch", intx_level, 1);
    cfg_msi_enable = 1;
    tick();
    chk("R8", "deassert first", intx_deassert_req, 1);
    chk("R8", "no msi yet", msi_req, 0);
    tick();
    chk("R8", "msi next cycle", msi_req, 1);
    chk("R8", "deassert gone", intx_deassert_req, 0);
    quiet();
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_gating();
    t_disable();
    t_msi();
    t_switch();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule